// File: doc/BRIEF.md
# Periodic Whole-Packet Dropper

This block sits in line on a framed packet stream: 64-bit data words travel alongside an 8-bit control word, with a write strobe going downstream and a ready signal coming back upstream. When dropping is switched off, every word passes straight through in the same cycle. When dropping is switched on, the block discards one complete packet out of every N and lets all the others through unchanged. Software sets N and the on/off switch through two registers.

The block finds packet boundaries from the control word. A packet may open with header words, carried with control 0xff. Body words follow, carried with control 0x00. The packet ends on the first word whose control is nonzero after body words have started, or on any word whose control is neither 0x00 nor 0xff. On the first word of each packet a 16-bit packet counter steps, and the drop decision is taken there. That decision then holds until the packet's last word. Words of a dropped packet are still taken from upstream, but they never reach downstream.

Top module: `drop_nth_filter`

## Requirements
- R1: After reset, pkt_count is 0, the enable register reads 0, the period register reads 10 and out_wr is low.
- R2: A write at reg_addr 0x0 sets enable from bit 0 of reg_wdata, and a write at reg_addr 0x4 sets the period N from all 16 bits. Reads are combinational: address 0x0 returns {15'b0, enable} and address 0x4 returns N. Writes to any other address change nothing, and reads from other addresses return 0.
- R3: While enable is 0 at a packet's first word, that packet is passed and pkt_count becomes 0 in the next cycle.
- R4: While enable is 1 at a packet's first word, pkt_count+1 is compared with N. If pkt_count+1 is at least N, the packet is dropped and pkt_count becomes 0; otherwise pkt_count becomes pkt_count+1. pkt_count changes only in the cycle after a packet's first word is accepted. With N=3, packets 3, 6, 9 and so on after enabling are dropped.
- R5: When enabled with N equal to 0 or 1, every packet is dropped.
- R6: Framing: a word with control 0xff before any body word is a header word, and control 0x00 is a body word. A nonzero control after a body word, or a control that is neither 0x00 nor 0xff, marks the packet's last word. The next accepted word starts a new packet.
- R7: For a passed packet, out_wr equals in_wr in the same cycle, and out_data and out_ctrl equal in_data and in_ctrl.
- R8: For a dropped packet, out_wr stays low for every one of its words. After its first word, in_rdy is high regardless of out_rdy.
- R9: Outside the remainder of a dropped packet, in_rdy equals out_rdy.
- R10: A register write made in the middle of a packet does not change whether that packet is passed or dropped. It takes effect from the next packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 64 | Upstream data word |
| in_ctrl | input | 8 | Upstream control word |
| in_wr | input | 1 | Upstream word valid |
| in_rdy | output | 1 | Ready to upstream |
| out_data | output | 64 | Downstream data word |
| out_ctrl | output | 8 | Downstream control word |
| out_wr | output | 1 | Downstream word valid |
| out_rdy | input | 1 | Ready from downstream |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| pkt_count | output | 16 | Packet counter |

## Verification
Some rules are checked on every cycle. Downstream never sees a write that upstream did not make. Ready passes from downstream to upstream. While the rest of a dropped packet is being discarded, nothing goes downstream and upstream sees ready. The counter either holds, steps by one or clears, and it moves only after an accepted word. The bench's scenarios are needed for the rest: the periodic drop pattern for a given N, drop-all for N of 0 and 1, boundary detection across the different ways a packet can end, register readback and ignored addresses, and register writes made mid-packet that must not split a packet's decision.

// File: rtl/drop_nth_filter.sv
module drop_nth_filter #(
  parameter int DATA_W  = 64,
  parameter int CTRL_W  = 8,
  parameter int CNT_W   = 16,
  parameter int ADDR_W  = 8,
  parameter int N_RESET = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CTRL_W-1:0] in_ctrl,
  input  logic              in_wr,
  output logic              in_rdy,
  output logic [DATA_W-1:0] out_data,
  output logic [CTRL_W-1:0] out_ctrl,
  output logic              out_wr,
  input  logic              out_rdy,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic [CNT_W-1:0]  pkt_count
);
  localparam logic [CTRL_W-1:0] HDR_CODE = {CTRL_W{1'b1}};
  localparam logic [ADDR_W-1:0] ADDR_EN  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_N   = ADDR_W'(4);
  localparam logic [1:0] S_IDLE = 2'd0, S_HDR = 2'd1, S_BODY = 2'd2;

  logic [1:0]       st;
  logic             en, held_drop;
  logic [CNT_W-1:0] period;
  logic [CNT_W:0]   cnt_next;
  logic             acc, start, is_last, hit, drop_cur;
  logic             inc_counter, rst_counter;

  assign acc      = in_wr & in_rdy;
  assign start    = acc && (st == S_IDLE);
  assign is_last  = (in_ctrl != '0) && ((st == S_BODY) || (in_ctrl != HDR_CODE));
  assign cnt_next = {1'b0, pkt_count} + 1'b1;
  assign hit      = cnt_next >= {1'b0, period};
  assign drop_cur = start ? (en & hit) : held_drop;

  assign inc_counter = start & en & ~hit;
  assign rst_counter = start & (~en | hit);

  assign in_rdy   = held_drop | out_rdy;
  assign out_wr   = acc & ~drop_cur;
  assign out_data = in_data;
  assign out_ctrl = in_ctrl;

  always_comb begin
    if (reg_addr == ADDR_EN)     reg_rdata = {{(CNT_W-1){1'b0}}, en};
    else if (reg_addr == ADDR_N) reg_rdata = period;
    else                         reg_rdata = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      held_drop <= 1'b0;
    end else if (acc) begin
      held_drop <= is_last ? 1'b0 : drop_cur;
      if (is_last)                                 st <= S_IDLE;
      else if (in_ctrl == HDR_CODE && st != S_BODY) st <= S_HDR;
      else                                         st <= S_BODY;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           pkt_count <= '0;
    else if (rst_counter) pkt_count <= '0;
    else if (inc_counter) pkt_count <= cnt_next[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en     <= 1'b0;
      period <= CNT_W'(N_RESET);
    end else if (reg_wr_en) begin
      if (reg_addr == ADDR_EN) en     <= reg_wdata[0];
      if (reg_addr == ADDR_N)  period <= reg_wdata;
    end
  end
endmodule

module drop_nth_filter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_wr,
  input logic             in_rdy,
  input logic             out_wr,
  input logic             out_rdy,
  input logic [CNT_W-1:0] pkt_count,
  input logic             en,
  input logic             held_drop
);
  p_out_needs_in_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr |-> in_wr);
  p_rdy_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_rdy |-> in_rdy);
  p_drop_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (held_drop && in_wr) |-> (!out_wr && in_rdy));
  p_disabled_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !held_drop && in_wr && in_rdy) |-> out_wr);
  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pkt_count == '0 || pkt_count == $past(pkt_count) + 1'b1 || $stable(pkt_count)));
  p_count_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_wr && in_rdy) |=> $stable(pkt_count));
endmodule

bind drop_nth_filter drop_nth_filter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_wr(in_wr), .in_rdy(in_rdy), .out_wr(out_wr),
  .out_rdy(out_rdy), .pkt_count(pkt_count), .en(en), .held_drop(held_drop)
);

// File: tb/drop_nth_filter_test.sv
`timescale 1ns/1ps
module drop_nth_filter_test;
  logic        clk = 0, rst_n = 0;
  logic [63:0] in_data = '0;
  logic [7:0]  in_ctrl = '0;
  logic        in_wr = 0, in_rdy, out_wr, out_rdy = 1;
  logic [63:0] out_data;
  logic [7:0]  out_ctrl;
  logic        reg_wr_en = 0;
  logic [7:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata, pkt_count;

  int tests = 0, fails = 0;
  bit m_en = 0;
  logic [15:0] m_n = 16'd10, m_cnt = 0;
  int dropped_seen = 0;

  drop_nth_filter uut (.*);

  always #4 clk = ~clk;

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr_en = 0;
    if (a == 8'h0) m_en = d[0];
    if (a == 8'h4) m_n = d;
  endtask

  task automatic rd_chk(logic [7:0] a, logic [15:0] exp, string req);
    @(negedge clk);
    reg_addr = a; #1;
    chk(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  task automatic decide(output bit d);
    logic [16:0] nx;
    nx = {1'b0, m_cnt} + 17'd1;
    if (!m_en) begin d = 0; m_cnt = 0; end
    else if (nx >= {1'b0, m_n}) begin d = 1; m_cnt = 0; end
    else begin d = 0; m_cnt = nx[15:0]; end
  endtask

  task automatic word(logic [7:0] c, bit d, bit first);
    logic [63:0] v;
    bool_rdy: begin end
    v = {$urandom, $urandom};
    @(negedge clk);
    in_data = v; in_ctrl = c; in_wr = 1;
    out_rdy = (d && !first) ? 1'($urandom % 2) : 1'b1;
    #1;
    if (d) chk(out_wr == 0, "R8 dropped word", out_wr, 0);
    else begin
      chk(out_wr == 1, "R7 passed word", out_wr, 1);
      chk(out_data == v && out_ctrl == c, "R7 data", out_data, v);
    end
    if (d && !first) chk(in_rdy == 1, "R8 rdy held", in_rdy, 1);
    else chk(in_rdy == out_rdy, "R9 rdy mirror", in_rdy, out_rdy);
    @(posedge clk); #1;
    in_wr = 0; out_rdy = 1;
  endtask

  task automatic pkt(int nh, int nb, logic [7:0] lc, bit mid, logic [7:0] ma, logic [15:0] md);
    bit d;
    int k;
    decide(d);
    if (d) dropped_seen++;
    k = 0;
    for (int i = 0; i < nh; i++) begin word(8'hff, d, k == 0); k++; if (mid && k == 1) wr_reg(ma, md); end
    for (int i = 0; i < nb; i++) begin word(8'h00, d, k == 0); k++; if (mid && k == 1) wr_reg(ma, md); end
    word(lc, d, k == 0);
    @(negedge clk);
    chk(pkt_count == m_cnt, m_en ? "R4 count" : "R3 count", pkt_count, m_cnt);
  endtask

  task automatic rnd_pkt();
    int nh, nb;
    logic [7:0] lc;
    nh = $urandom % 3; nb = $urandom % 4;
    lc = 8'h01 << ($urandom % 7);
    if (nb > 0 && ($urandom % 3 == 0)) lc = 8'hff;
    pkt(nh, nb, lc, 0, 8'h0, 16'h0);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(pkt_count == 0, "R1 count", pkt_count, 0);
    chk(out_wr == 0, "R1 out_wr", out_wr, 0);
    rd_chk(8'h0, 16'h0, "R1 enable");
    rd_chk(8'h4, 16'd10, "R1 period");

    for (int i = 0; i < 20; i++) rnd_pkt();
    chk(dropped_seen == 0, "R3 none dropped", dropped_seen, 0);

    wr_reg(8'h4, 16'd3);
    wr_reg(8'h0, 16'h1);
    rd_chk(8'h0, 16'h1, "R2 enable readback");
    rd_chk(8'h4, 16'd3, "R2 period readback");
    dropped_seen = 0;
    for (int i = 0; i < 30; i++) rnd_pkt();
    chk(dropped_seen == 10, "R4 one in three", dropped_seen, 10);

    wr_reg(8'h8, 16'h5555);
    rd_chk(8'h8, 16'h0, "R2 unknown reads zero");
    rd_chk(8'h0, 16'h1, "R2 enable unchanged");
    rd_chk(8'h4, 16'd3, "R2 period unchanged");

    wr_reg(8'h4, 16'd0);
    dropped_seen = 0;
    for (int i = 0; i < 5; i++) rnd_pkt();
    wr_reg(8'h4, 16'd1);
    for (int i = 0; i < 5; i++) rnd_pkt();
    chk(dropped_seen == 10, "R5 drop all", dropped_seen, 10);

    pkt(0, 0, 8'h04, 0, 8'h0, 16'h0);
    pkt(2, 0, 8'h10, 0, 8'h0, 16'h0);
    pkt(1, 2, 8'hff, 0, 8'h0, 16'h0);
    chk(pkt_count == 0, "R6 framing count", pkt_count, 0);

    wr_reg(8'h4, 16'd1);
    pkt(1, 3, 8'h01, 1, 8'h0, 16'h0);
    pkt(1, 1, 8'h02, 0, 8'h0, 16'h0);
    wr_reg(8'h0, 16'h1);
    wr_reg(8'h4, 16'd2);
    pkt(1, 2, 8'h01, 1, 8'h4, 16'd1);
    pkt(1, 2, 8'h01, 0, 8'h0, 16'h0);
    chk(pkt_count == 0, "R10 deferred", pkt_count, 0);

    for (int i = 0; i < 150; i++) begin
      if (i % 25 == 0) begin
        wr_reg(8'h4, 16'($urandom % 6));
        wr_reg(8'h0, 16'($urandom % 4 != 0));
      end
      rnd_pkt();
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule